// File: doc/BRIEF.md
# Serial Channel Data Register with Transfer-Clock Divider

This block holds one serial channel's 16-bit data and configuration word and generates the transfer-clock enable that the channel's shift logic runs on. The low byte is the transmit/receive buffer. Software loads it over the bus before a transmission. The shift logic loads it with a receive strobe when a character arrives. The upper seven bits hold a divider setting N. While the channel runs and the internal clock source is selected, this setting turns the operating clock into a one-cycle tick every 2×(N+1) cycles.

Access depends on whether the channel is running.
- While the channel is stopped, software can read and write the divider field.
- While the channel runs, the divider field is locked and reads as zero. Bus writes can only change the buffer byte.
- A write to the low byte alone while the channel is stopped clears the divider field.

An error flag reports a divider setting that is illegal for the selected framing mode while the channel runs.

The receive strobe is a plain pulse and is always accepted in the cycle it is asserted, so it has no ready handshake. The bus write port is a plain single-cycle strobe with byte lanes. A word write asserts both lanes. Reads are combinational from the register state.

Top module: `sdr_unit`

## Requirements
- R1: After reset, the read data is 0000h, the transfer tick is low and the error flag is low.
- R2: Bit 8 of the read data is always 0, whatever value is written to it.
- R3: While the channel is stopped, a write with both lanes stores bits 15:9 as the divider setting and bits 7:0 as the buffer. Both fields read back unchanged.
- R4: While the channel runs, read bits 15:9 are 0 and the high lane of any write is ignored. After the channel stops, the earlier divider setting reads back.
- R5: While the channel runs, a write that includes the low lane updates the buffer byte.
- R6: While the channel is stopped, a write with only the low lane asserted stores the buffer byte and clears the divider setting to 0.
- R7: While the channel is stopped, a write with only the high lane asserted updates the divider setting and leaves the buffer unchanged.
- R8: A receive strobe loads rx_data into bits 7:0. It wins over a bus write to the low lane in the same cycle.
- R9: With run=1 and clk_sel=0, the tick first fires in the 2×(N+1)-th cycle after enable. It then fires once every 2×(N+1) cycles and is never high two cycles in a row.
- R10: With clk_sel=1 or run=0 there is no tick, and the divide count restarts from zero when the tick path becomes active again.
- R11: The error flag is high exactly when run=1 and either mode=01 (UART) with N≤1, or mode=10 (I2C) with N=0. Modes 00 and 11 never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel enable |
| clk_sel | input | 1 | Transfer clock source: 0 selects the internal divider |
| mode | input | 2 | Framing mode: 00 other, 01 UART, 10 I2C, 11 other |
| wr_en | input | 1 | Bus write strobe |
| wr_lo | input | 1 | Low byte lane (bits 7:0) select |
| wr_hi | input | 1 | High byte lane (bits 15:8) select |
| wdata | input | 16 | Bus write data |
| rdata | output | 16 | Bus read data |
| rx_load | input | 1 | Receive strobe from the shift logic |
| rx_data | input | 8 | Received byte |
| tick | output | 1 | One-cycle transfer-clock enable |
| cfg_err | output | 1 | Illegal divider setting for the active mode |

## Verification
The bench sends random mixes of word, low-lane and high-lane writes, receive strobes and enable toggles against a reference model. A design that let the high lane through while running, or forgot to clear the divider on a stopped low-lane write, would show a wrong divider field after the next stop. A receive strobe and a bus write in the same cycle test priority: the wrong winner leaves the bus byte in the buffer. Directed runs with N=0, 1, 2, 127 and random N check the first-tick cycle and the period, which catch an off-by-one in the count limit or a counter that does not restart on enable. Each mode is checked at the error boundaries N=0, 1 and 2, which catches a wrong comparison.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  localparam int DIV_W_DEF = 7;
  localparam int BUF_W_DEF = 8;

  typedef enum logic [1:0] {
    MODE_OTHER = 2'b00,
    MODE_UART  = 2'b01,
    MODE_I2C   = 2'b10,
    MODE_SPARE = 2'b11
  } mode_e;
endpackage

// File: rtl/sdr_regfile.sv
module sdr_regfile #(
  parameter int DIV_W = sdr_pkg::DIV_W_DEF,
  parameter int BUF_W = sdr_pkg::BUF_W_DEF,
  localparam int WORD_W = DIV_W + 1 + BUF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rx_load,
  input  logic [BUF_W-1:0]  rx_data,
  output logic [DIV_W-1:0]  div_q,
  output logic [BUF_W-1:0]  buf_q,
  output logic [WORD_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      buf_q <= '0;
    end else begin
      // buffer: receive strobe wins over bus low-lane write
      if (rx_load)
        buf_q <= rx_data;
      else if (wr_en && wr_lo)
        buf_q <= wdata[BUF_W-1:0];
      // divider field: writable only while stopped
      if (!run && wr_en) begin
        if (wr_hi)
          div_q <= wdata[WORD_W-1 -: DIV_W];
        else if (wr_lo)
          div_q <= '0;
      end
    end
  end

  assign rdata = {(run ? {DIV_W{1'b0}} : div_q), 1'b0, buf_q};

  // R4: divider field cannot move while the channel runs
  p_div_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(div_q));
  // R6: stopped low-only write clears the divider
  p_lo_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wr_en && wr_lo && !wr_hi) |=> (div_q == '0));
  // R8: receive strobe always lands in the buffer
  p_rx_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> (buf_q == $past(rx_data)));
endmodule

// File: rtl/sdr_clkdiv.sv
module sdr_clkdiv #(
  parameter int DIV_W = sdr_pkg::DIV_W_DEF,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clk_sel,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             active;

  // 2*(N+1)-1 == {N, 1}
  assign last   = {div_n, 1'b1};
  assign active = run && !clk_sel;

  always_ff @(posedge clk) begin
    if (!rst_n || !active)
      cnt <= '0;
    else if (cnt == last)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  assign tick = active && (cnt == last);

  // R9: tick never fires on consecutive cycles
  p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R10: counter restarts while the tick path is idle
  p_idle_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0));
endmodule

// File: rtl/sdr_legal.sv
module sdr_legal #(
  parameter int DIV_W = sdr_pkg::DIV_W_DEF
) (
  input  logic             run,
  input  logic [1:0]       mode,
  input  logic [DIV_W-1:0] div_n,
  output logic             err
);
  import sdr_pkg::*;
  mode_e m;
  logic  bad;

  always_comb begin
    m = mode_e'(mode);
    unique case (m)
      MODE_UART: bad = (div_n <= DIV_W'(1));
      MODE_I2C:  bad = (div_n == '0);
      default:   bad = 1'b0;
    endcase
  end

  assign err = run && bad;
endmodule

// File: rtl/sdr_unit.sv
module sdr_unit #(
  parameter int DIV_W = sdr_pkg::DIV_W_DEF,
  parameter int BUF_W = sdr_pkg::BUF_W_DEF,
  localparam int WORD_W = DIV_W + 1 + BUF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clk_sel,
  input  logic [1:0]        mode,
  input  logic              wr_en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic              rx_load,
  input  logic [BUF_W-1:0]  rx_data,
  output logic              tick,
  output logic              cfg_err
);
  logic [DIV_W-1:0] div_q;
  logic [BUF_W-1:0] buf_q;

  sdr_regfile #(.DIV_W(DIV_W), .BUF_W(BUF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .run(run),
    .wr_en(wr_en), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wdata),
    .rx_load(rx_load), .rx_data(rx_data),
    .div_q(div_q), .buf_q(buf_q), .rdata(rdata)
  );

  sdr_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .clk_sel(clk_sel),
    .div_n(div_q), .tick(tick)
  );

  sdr_legal #(.DIV_W(DIV_W)) u_legal (
    .run(run), .mode(mode), .div_n(div_q), .err(cfg_err)
  );

  // R2: the reserved bit never reads as one
  p_bit8_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[BUF_W] == 1'b0);
  // R11: error flag only while running
  p_err_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> run);
  // R1: outputs quiet in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!tick && !cfg_err));
endmodule

// File: tb/sdr_unit_test.sv
module sdr_unit_test;
  logic clk = 0, rst_n = 0, run = 0, clk_sel = 0;
  logic [1:0] mode = 0;
  logic wr_en = 0, wr_lo = 0, wr_hi = 0, rx_load = 0;
  logic [15:0] wdata = 0, rdata;
  logic [7:0] rx_data = 0;
  logic tick, cfg_err;
  int errors = 0, checks = 0;
  logic [6:0] m_div = 0;
  logic [7:0] m_buf = 0;

  always #2 clk = ~clk;

  sdr_unit uut (.clk, .rst_n, .run, .clk_sel, .mode, .wr_en, .wr_lo, .wr_hi,
                .wdata, .rdata, .rx_load, .rx_data, .tick, .cfg_err);

  function automatic logic [15:0] exp_read(logic r);
    return {(r ? 7'd0 : m_div), 1'b0, m_buf};
  endfunction

  function automatic logic exp_err(logic r, logic [1:0] md, logic [6:0] n);
    return r && ((md == 2'b01 && n <= 7'd1) || (md == 2'b10 && n == 7'd0));
  endfunction

  task automatic chk(logic ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // drive at negedge, take one edge, update model, return at next negedge
  task automatic op(logic en, logic lo, logic hi, logic [15:0] d, logic rx, logic [7:0] rd);
    wr_en = en; wr_lo = lo; wr_hi = hi; wdata = d; rx_load = rx; rx_data = rd;
    @(posedge clk);
    if (rx) m_buf = rd;
    else if (en && lo) m_buf = d[7:0];
    if (!run && en) begin
      if (hi) m_div = d[15:9];
      else if (lo) m_div = 7'd0;
    end
    @(negedge clk);
    wr_en = 0; wr_lo = 0; wr_hi = 0; rx_load = 0;
  endtask

  task automatic chk_read(string req);
    #1 chk(rdata === exp_read(run), req, rdata, exp_read(run));
  endtask

  task automatic tick_run(logic [6:0] n, string req);
    int p = 2 * (int'(n) + 1);
    int bad = 0;
    run = 0; clk_sel = 0;
    op(1, 1, 1, {n, 9'h0AB}, 0, 0);
    run = 1;
    for (int i = 1; i <= 3 * p; i++) begin
      #1;
      if (tick !== ((i % p) == 0)) bad++;
      @(negedge clk);
    end
    chk(bad == 0, req, bad, 0);
    run = 0;
    @(negedge clk);
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    // R1 reset state
    #1 chk(rdata === 16'h0 && !tick && !cfg_err, "R1", {rdata, tick, cfg_err}, 0);
    rst_n = 1; @(negedge clk);

    // R3 + R2: word write stopped, bit 8 set in data
    op(1, 1, 1, 16'hA5C3 | 16'h0100, 0, 0); chk_read("R3");
    #1 chk(rdata[8] === 1'b0, "R2", rdata[8], 0);
    // R7 high only
    op(1, 0, 1, 16'h3F00, 0, 0); chk_read("R7");
    // R4 running: hidden and locked
    run = 1; op(1, 1, 1, 16'hFE11, 0, 0); chk_read("R4");
    // R5 low byte updated while running
    chk(rdata[7:0] === 8'h11, "R5", rdata[7:0], 8'h11);
    run = 0; @(negedge clk); chk_read("R4");
    // R6 low only stopped clears divider
    op(1, 1, 0, 16'hFF5A, 0, 0); chk_read("R6");
    // R8 priority over simultaneous bus write
    op(1, 1, 0, 16'h0077, 1, 8'hC4); chk_read("R8");
    chk(rdata[7:0] === 8'hC4, "R8", rdata[7:0], 8'hC4);

    // R9 periods, boundary and random
    tick_run(7'd0, "R9");
    tick_run(7'd1, "R9");
    tick_run(7'd2, "R9");
    tick_run(7'd127, "R9");
    tick_run(7'($urandom_range(3, 40)), "R9");

    // R10 clk_sel=1 silences tick; restart after switching back
    begin
      int seen = 0;
      op(1, 1, 1, {7'd1, 9'h0}, 0, 0);
      run = 1; clk_sel = 1;
      for (int i = 0; i < 20; i++) begin #1 if (tick) seen++; @(negedge clk); end
      chk(seen == 0, "R10", seen, 0);
      clk_sel = 0; seen = 0;
      for (int i = 1; i <= 4; i++) begin #1 if (tick !== (i == 4)) seen++; @(negedge clk); end
      chk(seen == 0, "R10", seen, 0);
      run = 0; @(negedge clk);
    end

    // R11 boundary sweep
    for (int md = 0; md < 4; md++)
      for (int n = 0; n < 3; n++) begin
        run = 0; mode = 2'(md);
        op(1, 0, 1, {7'(n), 9'h0}, 0, 0);
        #1 chk(cfg_err === 1'b0, "R11", cfg_err, 0);
        run = 1; @(negedge clk);
        #1 chk(cfg_err === exp_err(1, 2'(md), 7'(n)), "R11", cfg_err, exp_err(1, 2'(md), 7'(n)));
        @(negedge clk);
      end

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [2:0] kind = 3'($urandom_range(0, 7));
      run = $urandom_range(0, 3) == 0;
      mode = 2'($urandom);
      op(kind != 0, kind[0] | (kind == 7), kind[1] | (kind == 7), 16'($urandom),
         $urandom_range(0, 4) == 0, 8'($urandom));
      chk_read("R3 R4 R5 R6 R7 R8 random");
      chk(cfg_err === exp_err(run, mode, m_div), "R11 random", cfg_err, exp_err(run, mode, m_div));
      @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule